// File: doc/BRIEF.md
# Prioritised Interrupt Daisy Chain

This block is the interrupt logic of a two-channel serial controller. It has six interrupt sources: receive, transmit and external/status for channel A and for channel B. They are ranked in a fixed order. Each source has a pending flag, an under-service flag and its own enable. A master enable gates the interrupt request. The enable-in and enable-out pins link this block into a wider chain of devices, so that a device higher in that chain can hold this one off.

An acknowledge strobe picks the highest pending source that is not blocked and marks it under service. It can also return a vector byte. When the status option is on, three bits of that byte name the winning source. Software ends the service of a source with a reset-highest command. That command clears only the highest-ranked under-service flag, so nested services unwind in order.

Top module: `irq_chain_top`

## Requirements
- R1: Source i (bit i of `src_req`/`src_en`) becomes pending on the clock edge after `src_req[i]` and `src_en[i]` are both 1. It stops being pending on the edge after either of them is 0. A source whose enable is 0 never raises `irq`.
- R2: `irq` is 0 whenever `mie` is 0, whatever the pending state.
- R3: While `iei` is 0, both `irq` and `ieo` are 0, and an acknowledge has no effect.
- R4: Bit index sets the rank, with index 0 the highest: 0 = A receive, 1 = A transmit, 2 = A external/status, 3 = B receive, 4 = B transmit, 5 = B external/status. The 3-bit status code of a source is its index.
- R5: `irq` is 1 exactly when `mie` and `iei` are 1 and some source is pending with no under-service flag set at its own rank or higher. A pending source of higher rank therefore still interrupts during a lower-ranked service (nesting).
- R6: `ieo` equals `iei`, except that it is 0 while any under-service flag is set, and 0 while `intack` is 1 and any source is pending.
- R7: An acknowledge happens on a clock edge where `intack`, `ack_rd` and `iei` are all 1. It sets the under-service flag of the winner, which is the highest-ranked pending source that is not blocked. If `vec_en` is 1, `vec_out` is loaded and `vec_drive` is 1 for the one following cycle. If `vec_en` is 0, the acknowledge gives no vector: `vec_out` holds and `vec_drive` stays 0.
- R8: When `vis` is 0, the vector is `base_vec`. When `vis` is 1, bits 3..1 of `base_vec` are replaced by the winner's status code, or by 3'b110 if there was no winner.
- R9: A pulse on `rst_ius` clears only the highest-ranked under-service flag that is set. If an acknowledge happens on the same edge, its winner is still set.
- R10: After reset no source is pending or under service, `irq` and `vec_drive` are 0, `vec_out` is 0 and `ieo` follows `iei`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_req | input | 6 | Source conditions, indexed by rank |
| src_en | input | 6 | Per-source interrupt enables |
| mie | input | 1 | Master interrupt enable |
| iei | input | 1 | Chain enable in |
| intack | input | 1 | Acknowledge cycle in progress |
| ack_rd | input | 1 | Acknowledge read strobe |
| vec_en | input | 1 | Acknowledge returns a vector |
| vis | input | 1 | Vector includes status |
| base_vec | input | 8 | Programmed vector base |
| rst_ius | input | 1 | Reset highest under-service command |
| irq | output | 1 | Interrupt request, active high |
| ieo | output | 1 | Chain enable out |
| vec_out | output | 8 | Vector of the last vectored acknowledge |
| vec_drive | output | 1 | One-cycle flag: vector returned |

## Verification
The assertions assume that the acknowledge and command strobes are synchronous single-cycle inputs, sampled only at rising clock edges. They also assume that `iei` is a level settled before each edge, not a glitching chain input. The stimulus drives every input only just after a falling edge, holds it for the whole cycle, and lowers the strobes again on the next cycle. Random stretches do allow an acknowledge and a reset-highest command on the same edge, because R9 defines that case.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
  localparam int NSRC     = 6;
  localparam int CODE_W   = 3;
  localparam int VEC_W    = 8;
  localparam logic [CODE_W-1:0] CODE_NONE = 3'b110;

  // isolate lowest set bit (rank 0 highest)
  function automatic logic [NSRC-1:0] lowest_one(input logic [NSRC-1:0] v);
    logic [NSRC-1:0] r;
    logic            seen;
    r    = '0;
    seen = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (v[i] && !seen) begin
        r[i] = 1'b1;
        seen = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [CODE_W-1:0] enc_code(input logic [NSRC-1:0] oh);
    logic [CODE_W-1:0] c;
    c = CODE_NONE;
    for (int i = 0; i < NSRC; i++) begin
      if (oh[i]) c = i[CODE_W-1:0];
    end
    return c;
  endfunction

  function automatic logic [VEC_W-1:0] merge_status(input logic [VEC_W-1:0] base,
                                                    input logic [CODE_W-1:0] code,
                                                    input logic vis);
    logic [VEC_W-1:0] v;
    v = base;
    if (vis) v[3:1] = code;
    return v;
  endfunction
endpackage

// File: rtl/irq_src_cell.sv
module irq_src_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic en,
  input  logic set_ius,
  input  logic clr_ius,
  output logic ip,
  output logic ius
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ip  <= 1'b0;
      ius <= 1'b0;
    end else begin
      ip <= req & en;
      if (set_ius)      ius <= 1'b1;
      else if (clr_ius) ius <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_prio.sv
module irq_prio
  import irq_chain_pkg::*;
(
  input  logic [NSRC-1:0] ip,
  input  logic [NSRC-1:0] ius,
  input  logic            iei,
  output logic [NSRC-1:0] win_oh,
  output logic [NSRC-1:0] hi_ius_oh,
  output logic            any_ok
);
  logic [NSRC-1:0] blk;
  logic [NSRC-1:0] ok;

  assign blk[0] = ius[0];
  genvar g;
  generate
    for (g = 1; g < NSRC; g++) begin : g_blk
      assign blk[g] = blk[g-1] | ius[g];
    end
  endgenerate

  assign ok        = ip & ~blk;
  assign any_ok    = |ok;
  assign win_oh    = iei ? lowest_one(ok) : '0;
  assign hi_ius_oh = lowest_one(ius);
endmodule

// File: rtl/irq_vec.sv
module irq_vec
  import irq_chain_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_fire,
  input  logic             vec_en,
  input  logic             vis,
  input  logic [NSRC-1:0]  win_oh,
  input  logic [VEC_W-1:0] base_vec,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_drive
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_out   <= '0;
      vec_drive <= 1'b0;
    end else begin
      vec_drive <= ack_fire & vec_en;
      if (ack_fire && vec_en)
        vec_out <= merge_status(base_vec, enc_code(win_oh), vis);
    end
  end
endmodule

// File: rtl/irq_chain_top.sv
module irq_chain_top
  import irq_chain_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_req,
  input  logic [NSRC-1:0]  src_en,
  input  logic             mie,
  input  logic             iei,
  input  logic             intack,
  input  logic             ack_rd,
  input  logic             vec_en,
  input  logic             vis,
  input  logic [VEC_W-1:0] base_vec,
  input  logic             rst_ius,
  output logic             irq,
  output logic             ieo,
  output logic [VEC_W-1:0] vec_out,
  output logic             vec_drive
);
  logic [NSRC-1:0] ip_vec;
  logic [NSRC-1:0] ius_vec;
  logic [NSRC-1:0] win_oh;
  logic [NSRC-1:0] hi_ius_oh;
  logic            any_ok;
  logic            ack_fire;

  assign ack_fire = intack & ack_rd & iei;

  genvar g;
  generate
    for (g = 0; g < NSRC; g++) begin : g_src
      irq_src_cell u_cell (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (src_req[g]),
        .en      (src_en[g]),
        .set_ius (ack_fire & win_oh[g]),
        .clr_ius (rst_ius & hi_ius_oh[g]),
        .ip      (ip_vec[g]),
        .ius     (ius_vec[g])
      );
    end
  endgenerate

  irq_prio u_prio (
    .ip        (ip_vec),
    .ius       (ius_vec),
    .iei       (iei),
    .win_oh    (win_oh),
    .hi_ius_oh (hi_ius_oh),
    .any_ok    (any_ok)
  );

  irq_vec u_vec (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack_fire  (ack_fire),
    .vec_en    (vec_en),
    .vis       (vis),
    .win_oh    (win_oh),
    .base_vec  (base_vec),
    .vec_out   (vec_out),
    .vec_drive (vec_drive)
  );

  assign irq = mie & iei & any_ok;
  assign ieo = iei & ~(|ius_vec) & ~(intack & (|ip_vec));
endmodule

// File: rtl/irq_chain_chk.sv
module irq_chain_chk
  import irq_chain_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            mie,
  input logic            iei,
  input logic            intack,
  input logic            ack_rd,
  input logic            vec_en,
  input logic            rst_ius,
  input logic            irq,
  input logic            ieo,
  input logic            vec_drive,
  input logic [NSRC-1:0] ius_vec,
  input logic [NSRC-1:0] src_en
);
  // R2
  mie_gates_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> mie);

  // R3
  iei_low_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !iei |-> (!irq && !ieo));

  // R6
  ius_blocks_ieo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ius_vec) |-> !ieo);

  // R7
  vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_drive |-> $past(intack && ack_rd && iei && vec_en));

  // R9
  ius_one_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ius && !(intack && ack_rd && iei) && (|ius_vec))
      |=> ($countones(ius_vec) == $past($countones(ius_vec)) - 1));

  // R1
  disabled_all_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_en == '0) && $past(src_en == '0)) |-> !irq);
endmodule

bind irq_chain_top irq_chain_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mie       (mie),
  .iei       (iei),
  .intack    (intack),
  .ack_rd    (ack_rd),
  .vec_en    (vec_en),
  .rst_ius   (rst_ius),
  .irq       (irq),
  .ieo       (ieo),
  .vec_drive (vec_drive),
  .ius_vec   (ius_vec),
  .src_en    (src_en)
);

// File: tb/tb_irq_chain_top.sv
`timescale 1ns/1ps
module tb_irq_chain_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] src_req = '0, src_en = '0;
  logic       mie = 0, iei = 1, intack = 0, ack_rd = 0, vec_en = 0, vis = 0, rst_ius = 0;
  logic [7:0] base_vec = 8'h00;
  logic       irq, ieo, vec_drive;
  logic [7:0] vec_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_chain_top dut (
    .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_en(src_en), .mie(mie),
    .iei(iei), .intack(intack), .ack_rd(ack_rd), .vec_en(vec_en), .vis(vis),
    .base_vec(base_vec), .rst_ius(rst_ius), .irq(irq), .ieo(ieo),
    .vec_out(vec_out), .vec_drive(vec_drive)
  );

  // reference model
  bit       m_ip  [6];
  bit       m_ius [6];
  bit [7:0] m_vec = 8'h00;
  bit       m_vd  = 1'b0;

  function automatic int pick_winner();
    if (!iei) return -1;
    for (int k = 0; k < 6; k++) begin
      if (m_ius[k]) return -1;
      if (m_ip[k]) return k;
    end
    return -1;
  endfunction

  function automatic bit exp_irq();
    return mie && iei && (pick_winner() >= 0);
  endfunction

  function automatic bit exp_ieo();
    bit any_s = 0, any_p = 0;
    for (int k = 0; k < 6; k++) begin
      if (m_ius[k]) any_s = 1;
      if (m_ip[k])  any_p = 1;
    end
    return iei && !any_s && !(intack && any_p);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 6; k++) begin m_ip[k] = 0; m_ius[k] = 0; end
      m_vec = 8'h00;
      m_vd  = 0;
    end else begin
      int  w, hi, code;
      bit  fire;
      bit  nius [6];
      w    = pick_winner();
      fire = intack && ack_rd && iei;
      hi   = -1;
      for (int k = 5; k >= 0; k--) if (m_ius[k]) hi = k;
      for (int k = 0; k < 6; k++) nius[k] = m_ius[k];
      if (rst_ius && hi >= 0) nius[hi] = 0;      // R9
      if (fire && w >= 0) nius[w] = 1;
      m_vd = fire && vec_en;
      if (fire && vec_en) begin
        code  = (w >= 0) ? w : 6;
        m_vec = base_vec;
        if (vis) m_vec[3:1] = code[2:0];
      end
      for (int k = 0; k < 6; k++) begin
        m_ip[k]  = src_req[k] && src_en[k];
        m_ius[k] = nius[k];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s t=%0t actual=%0h expected=%0h", req, $time, act, expv);
    end
  endtask

  // compare every cycle, well away from the rising edge
  always @(negedge clk) begin
    #5;
    if (!done && $time > 30) begin
      chk(irq == exp_irq(),     "R1/R2/R3/R5/R9 irq", irq, exp_irq());
      chk(ieo == exp_ieo(),     "R3/R6 ieo", ieo, exp_ieo());
      chk(vec_out == m_vec,     "R4/R8 vec_out", vec_out, m_vec);
      chk(vec_drive == m_vd,    "R7 vec_drive", vec_drive, m_vd);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic ack(input bit ve);
    intack = 1; cyc(1);
    ack_rd = 1; vec_en = ve; cyc(1);
    ack_rd = 0; intack = 0; vec_en = 0; cyc(1);
  endtask

  task automatic rst_cmd();
    rst_ius = 1; cyc(1);
    rst_ius = 0; cyc(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    cyc(2);
    // R10: reset state
    chk(irq == 0 && vec_drive == 0, "R10 reset irq/vec_drive", {irq, vec_drive}, 0);
    chk(vec_out == 8'h00, "R10 reset vec_out", vec_out, 0);
    chk(ieo == iei, "R10 reset ieo", ieo, iei);
    rst_n = 1; cyc(2);

    // R2: master enable off
    src_req = 6'h3F; src_en = 6'h3F; cyc(3);
    chk(irq == 0, "R2 mie off", irq, 0);
    // R1: enables off
    mie = 1; src_en = 6'h00; cyc(3);
    chk(irq == 0, "R1 enables off", irq, 0);
    src_req = '0; cyc(2);

    // R4 R8: each source alone, vector with status
    base_vec = 8'hA5; vis = 1;
    for (int s = 0; s < 6; s++) begin
      src_req = 6'b1 << s; src_en = 6'h3F; cyc(2);
      ack(1);
      chk(vec_out == ((8'hA5 & 8'hF1) | (s << 1)), "R4/R8 code", vec_out, s);
      src_req = '0; rst_cmd();
    end
    vis = 0; src_req = 6'b000100; cyc(2); ack(1);
    chk(vec_out == 8'hA5, "R8 no status", vec_out, 8'hA5);
    src_req = '0; rst_cmd();

    // R7: acknowledge without vector
    base_vec = 8'h3C; src_req = 6'b001000; cyc(2); ack(0);
    chk(vec_out == 8'hA5, "R7 vector held", vec_out, 8'hA5);
    chk(ieo == 0, "R6 ius blocks ieo", ieo, 0);
    src_req = '0; rst_cmd();

    // R5 R9: nesting, B external first then A receive
    vis = 1; src_req = 6'b100000; cyc(2); ack(1);
    src_req = 6'b100001; cyc(2);
    chk(irq == 1, "R5 higher nests", irq, 1);
    ack(1);
    chk(vec_out[3:1] == 3'd0, "R4 nested winner", vec_out[3:1], 0);
    src_req = 6'b000000; rst_cmd();
    chk(ieo == 0, "R9 lower ius still held", ieo, 0);
    rst_cmd();
    chk(ieo == 1, "R9 all released", ieo, 1);

    // R3: iei low
    src_req = 6'b000010; iei = 0; cyc(2); ack(1);
    chk(irq == 0 && ieo == 0, "R3 iei low", {irq, ieo}, 0);
    iei = 1; cyc(2);
    chk(irq == 1, "R3 iei restored", irq, 1);
    // R8: no winner code
    src_req = '0; cyc(2); ack(1);
    chk(vec_out[3:1] == 3'b110, "R8 none code", vec_out[3:1], 6);

    // random mixed traffic
    for (int n = 0; n < 3000; n++) begin
      src_req  = 6'($urandom);
      src_en   = 6'($urandom) | 6'($urandom);
      mie      = ($urandom % 8) != 0;
      iei      = ($urandom % 6) != 0;
      intack   = ($urandom % 3) == 0;
      ack_rd   = intack && ($urandom % 2);
      vec_en   = $urandom % 2;
      vis      = $urandom % 2;
      base_vec = 8'($urandom);
      rst_ius  = ($urandom % 4) == 0;
      cyc(1);
    end
    intack = 0; ack_rd = 0; rst_ius = 0; cyc(3);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule